// File: doc/BRIEF.md
# Chained FIFO Depth Expansion Controller

This block builds one deep first-in first-out queue out of several identical storage slices. Each slice holds a short queue of its own. The slices share the write strobe, the read strobe and the data buses. Two permissions decide which slice acts: a write token and a read token. A slice holds the write token while it is the one that accepts writes. It holds the read token while it is the one that supplies reads. When a slice stores into its last location, it raises its write-handoff line. The next slice in the ring sees that line on its own handoff input and takes the write token at that clock edge. Reads move the read token around the ring in the same way on a separate line. Each handoff line carries one direction only, so a receiving slice always knows which token it has been given.

A wrapper instantiates the slices and wires each handoff output to the next slice's handoff input, with the last slice wrapping round to the first. One slice is named the first-load slice by a parameter, and only that slice holds both tokens after reset. Each slice raises an active-low full or empty indication only when it holds the matching token. The wrapper combines the indications of all slices into a composite full flag and a composite empty flag. There is no threshold flag and no replay-from-start operation in this mode. Read data is registered. The shared read bus carries data only from the slice that performed the read and is zero otherwise.

Top module: `fifo_chain`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `empty` is 1, `full` is 0, `rd_valid` is 0 and `rd_data` is 0. After reset every slice pointer is at location zero and only slice `FIRST_SLICE` holds the write and read tokens.
- R2: Words leave the chain in exactly the order they were accepted, including across slice boundaries.
- R3: Exactly one slice holds the write token at any time. A write into a slice's last location (index `SLICE_DEPTH-1`) passes the token to the next slice in the ring at that clock edge, so the next accepted write goes to the next slice.
- R4: Exactly one slice holds the read token at any time. A read of a slice's last location passes the read token to the next slice in the same way.
- R5: `full` is 1 exactly when `SLICES*SLICE_DEPTH` words are stored. A write request while `full` is 1 is ignored: nothing is stored, and `full` and the read-out sequence are unaffected.
- R6: `empty` is 1 exactly when no word is stored. A read request while `empty` is 1 is ignored: `rd_valid` stays 0 in the next cycle.
- R7: An accepted read (`rd_en`=1 while `empty`=0) produces `rd_valid`=1 with the word on `rd_data` in the following cycle.
- R8: A read and a write requested in the same cycle are both accepted when the chain is neither full nor empty. A write is blocked by `full` even when a read is requested in the same cycle. A read is blocked by `empty` even when a write is requested in the same cycle.
- R9: The tokens wrap from the last slice back to the first, so sustained traffic of many times the total capacity keeps order and flag correctness.
- R10: Only the slice that performed a read drives the shared read bus. In every cycle where `rd_valid` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rd_data | output | DATA_W | Word read in the previous cycle, zero when none |
| rd_valid | output | 1 | rd_data carries a word |
| full | output | 1 | Composite full flag, active high |
| empty | output | 1 | Composite empty flag, active high |

## Verification
The bench goes after the instants when a token crosses a slice boundary. Off-by-one handling of the last location shows there: a word would land in the wrong slice or be read twice, and the read-out order would break. It fills the chain past capacity and drains it past empty. A design that let a blocked request reach a slice would show a surplus word, a spurious `rd_valid` or a flag that flips too early. A long sweep of all four request combinations, with the write/read choice driven pseudo-randomly, sends the tokens round the ring many times and runs simultaneous read and write at the full and empty edges. A wrong wrap or a read bus driven by the wrong slice would appear as corrupt data or nonzero idle data.

// File: rtl/chain_pkg.sv
package chain_pkg;

    // Ring predecessor of a slice index (the slice whose handoff feeds it).
    function automatic int unsigned ring_prev(int unsigned idx, int unsigned n);
        return (idx == 0) ? (n - 1) : (idx - 1);
    endfunction

    // Address width for a slice of the given depth (at least one bit).
    function automatic int unsigned addr_bits(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/chain_slice.sv
module chain_slice
    import chain_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_n,
    input  logic              hand_wr_in,
    input  logic              hand_rd_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              hand_wr_out,
    output logic              hand_rd_out,
    output logic              full_n,
    output logic              empty_n,
    output logic              wtok,
    output logic              rtok,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    localparam int unsigned AW = addr_bits(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        logic              wt;
        logic              rt;
        logic [DATA_W-1:0] q;
        logic              qv;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_go, rd_go;

    always_comb begin
        wr_go = wr_en && st_q.wt && (st_q.cnt != CNT_MAX);
        rd_go = rd_en && st_q.rt && (st_q.cnt != '0);

        hand_wr_out = wr_go && (st_q.wp == LAST_LOC);
        hand_rd_out = rd_go && (st_q.rp == LAST_LOC);

        st_d = st_q;
        if (wr_go) begin
            st_d.wp = (st_q.wp == LAST_LOC) ? '0 : st_q.wp + AW'(1);
        end
        if (rd_go) begin
            st_d.rp = (st_q.rp == LAST_LOC) ? '0 : st_q.rp + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(wr_go) - CW'(rd_go);
        st_d.wt  = (st_q.wt && !hand_wr_out) || hand_wr_in;
        st_d.rt  = (st_q.rt && !hand_rd_out) || hand_rd_in;
        st_d.q   = rd_go ? mem[st_q.rp] : '0;
        st_d.qv  = rd_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp  <= '0;
            st_q.rp  <= '0;
            st_q.cnt <= '0;
            st_q.wt  <= !first_n;
            st_q.rt  <= !first_n;
            st_q.q   <= '0;
            st_q.qv  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[st_q.wp] <= wr_data;
        end
    end

    assign full_n   = !(st_q.wt && (st_q.cnt == CNT_MAX));
    assign empty_n  = !(st_q.rt && (st_q.cnt == '0));
    assign wtok     = st_q.wt;
    assign rtok     = st_q.rt;
    assign dout     = st_q.q;
    assign dout_vld = st_q.qv;

endmodule

// File: rtl/chain_flags.sv
module chain_flags #(
    parameter int unsigned SLICES = 3
) (
    input  logic [SLICES-1:0] full_n_vec,
    input  logic [SLICES-1:0] empty_n_vec,
    output logic              full,
    output logic              empty
);
    // Active-low indications: any slice pulling low sets the composite flag.
    assign full  = !(&full_n_vec);
    assign empty = !(&empty_n_vec);
endmodule

// File: rtl/chain_rdmux.sv
module chain_rdmux #(
    parameter int unsigned SLICES = 3,
    parameter int unsigned DATA_W = 9
) (
    input  logic [SLICES*DATA_W-1:0] data_flat,
    input  logic [SLICES-1:0]        vld_vec,
    output logic [DATA_W-1:0]        dout,
    output logic                     dvld
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < SLICES; i++) begin
            if (vld_vec[i]) begin
                dout = dout | data_flat[i*DATA_W +: DATA_W];
            end
        end
        dvld = |vld_vec;
    end
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import chain_pkg::*;
#(
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned SLICE_DEPTH = 4,
    parameter int unsigned SLICES      = 3,
    parameter int unsigned FIRST_SLICE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full,
    output logic              empty
);
    logic [SLICES-1:0]        hand_wr, hand_rd;
    logic [SLICES-1:0]        full_n_vec, empty_n_vec;
    logic [SLICES-1:0]        wtok_vec, rtok_vec;
    logic [SLICES-1:0]        vld_vec;
    logic [SLICES*DATA_W-1:0] data_flat;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        localparam int unsigned PREV = ring_prev(g, SLICES);
        chain_slice #(
            .DATA_W (DATA_W),
            .DEPTH  (SLICE_DEPTH)
        ) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .first_n     ((g == FIRST_SLICE) ? 1'b0 : 1'b1),
            .hand_wr_in  (hand_wr[PREV]),
            .hand_rd_in  (hand_rd[PREV]),
            .wr_en       (wr_en),
            .wr_data     (wr_data),
            .rd_en       (rd_en),
            .hand_wr_out (hand_wr[g]),
            .hand_rd_out (hand_rd[g]),
            .full_n      (full_n_vec[g]),
            .empty_n     (empty_n_vec[g]),
            .wtok        (wtok_vec[g]),
            .rtok        (rtok_vec[g]),
            .dout        (data_flat[g*DATA_W +: DATA_W]),
            .dout_vld    (vld_vec[g])
        );
    end

    chain_flags #(.SLICES(SLICES)) u_flags (
        .full_n_vec  (full_n_vec),
        .empty_n_vec (empty_n_vec),
        .full        (full),
        .empty       (empty)
    );

    chain_rdmux #(.SLICES(SLICES), .DATA_W(DATA_W)) u_rdmux (
        .data_flat (data_flat),
        .vld_vec   (vld_vec),
        .dout      (rd_data),
        .dvld      (rd_valid)
    );

endmodule

// File: rtl/chain_chk.sv
module chain_chk #(
    parameter int unsigned SLICES = 3,
    parameter int unsigned DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [SLICES-1:0] wtok_vec,
    input logic [SLICES-1:0] rtok_vec,
    input logic [SLICES-1:0] vld_vec
);
    // R3
    wr_token_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wtok_vec) == 1);

    // R4
    rd_token_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rtok_vec) == 1);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R6
    no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> !rd_valid);

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> rd_valid);

    // R10
    rd_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R10
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_vec));

endmodule

bind fifo_chain chain_chk #(.SLICES(SLICES), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .wtok_vec (wtok_vec),
    .rtok_vec (rtok_vec),
    .vld_vec  (vld_vec)
);

// File: tb/tb_fifo_chain.sv
`timescale 1ns/1ps
module tb_fifo_chain;
    localparam int W   = 9;
    localparam int D   = 4;
    localparam int N   = 3;
    localparam int CAP = D * N;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, rd_en;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic         rd_valid, full, empty;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [W-1:0] model[$];
    logic [15:0]  lfsr = 16'hACE1;

    always #2 clk = ~clk;

    fifo_chain #(.DATA_W(W), .SLICE_DEPTH(D), .SLICES(N), .FIRST_SLICE(0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .empty(empty)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    // Called at a falling edge; leaves time at the next falling edge.
    task automatic step(input logic w, input logic [W-1:0] wd, input logic r, input string tag);
        logic         acc_w, acc_r;
        logic [W-1:0] head;
        wr_en   = w;
        wr_data = wd;
        rd_en   = r;
        check("R5", "full flag", int'(full), int'(model.size() == CAP));
        check("R6", "empty flag", int'(empty), int'(model.size() == 0));
        acc_w = w && (model.size() != CAP);
        acc_r = r && (model.size() != 0);
        head  = acc_r ? model[0] : '0;
        @(posedge clk);
        if (acc_r) void'(model.pop_front());
        if (acc_w) model.push_back(wd);
        @(negedge clk);
        check("R7", "rd_valid", int'(rd_valid), int'(acc_r));
        if (acc_r) check(tag, "rd_data", int'(rd_data), int'(head));
        else       check("R10", "idle rd_data", int'(rd_data), 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1", "empty in reset", int'(empty), 1);
        check("R1", "full in reset", int'(full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "empty after reset", int'(empty), 1);
        check("R1", "full after reset", int'(full), 0);
        check("R1", "rd_valid after reset", int'(rd_valid), 0);
        check("R1", "rd_data after reset", int'(rd_data), 0);

        // R3 R5: fill across every slice boundary and push past capacity
        for (int i = 0; i < CAP + 3; i++) step(1'b1, W'(i + 1), 1'b0, "R3");
        check("R5", "stored count", model.size(), CAP);

        // R2 R4: drain in order, then read past empty (R6)
        for (int i = 0; i < CAP; i++) step(1'b0, '0, 1'b1, "R2,R4");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R6");
        for (int i = 0; i < 3; i++) step(1'b1, W'(200 + i), 1'b1, "R8");

        // R8: concurrent traffic at the full edge
        while (model.size() < CAP) step(1'b1, W'(model.size() + 50), 1'b0, "R8");
        for (int i = 0; i < 20; i++) step(1'b1, W'(300 + i), 1'b1, "R8");

        // R9: long sweep of all request combinations, many ring laps
        for (int i = 0; i < 4000; i++) begin
            logic w, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 1000) begin
                w = i[0];
                r = i[1];
            end else if (i < 2500) begin
                w = lfsr[0] | lfsr[1];
                r = lfsr[2];
            end else begin
                w = lfsr[0];
                r = lfsr[2] | lfsr[3];
            end
            step(w, lfsr[W-1:0], r, "R9");
        end

        while (model.size() != 0) step(1'b0, '0, 1'b1, "R9");
        step(1'b0, '0, 1'b1, "R6");
        finish_run();
    end
endmodule